// File: doc/BRIEF.md
# Direct-Access Segment Tree

This block gives one 64-bit request port random read and write access to a large set of 64-bit state segments. The segment address is decoded one field at a time as the request descends through a tree of registered nodes. The root node splits the space in two, and every later level splits it in four. So any single segment is reached in one access without shifting through its neighbours. On a write, the addressed segment gets a one-cycle load enable and the write data. On a read, the addressed segment's data climbs back through the same levels to the root port. The segments themselves sit outside the block. They present their contents on a flat read bus and take new values when their load enable pulses.

A small controller allows one access in flight at a time. It has three states. ST_IDLE holds ready high. The accept transition (valid seen while idle) moves it to ST_DESCEND, where the request walks down one level per cycle. At the bottom, the write_done transition returns a write to ST_IDLE, and the turn transition sends a read to ST_ASCEND. In ST_ASCEND the data climbs one level per cycle. The respond transition pulses the response and returns to ST_IDLE. The depth and both fanouts are parameters. The default is four levels (fanouts 2, 4, 4, 4, giving 128 segments) with an 8-bit address, so part of the address range is out of range. Five levels reach 512 segments.

Top module: `dast_tree`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, seg_load is all zero and rsp_rdata is zero.
- R2: A request is accepted in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the next cycle on. It returns to 1 in cycle LEVELS+1 after the request cycle for a write, and in cycle 2*LEVELS+1 for a read.
- R3: Segment i is addressed by req_addr value i. The root decodes the top ROOT_FAN_LOG bits of the used address field, and each later level decodes the next NODE_FAN_LOG bits downward. Distinct addresses therefore never alias.
- R4: A write to segment i raises seg_load[i] for exactly one cycle, LEVELS cycles after the request cycle, with seg_wdata equal to the request's write data in that cycle.
- R5: At most one seg_load bit is high in any cycle, and only the addressed bit ever rises, so every other segment keeps its value.
- R6: A read of segment i raises rsp_valid for one cycle, 2*LEVELS cycles after the request cycle, with rsp_rdata equal to segment i's contents.
- R7: A read never raises any seg_load bit.
- R8: An address with any bit set at or above position ROOT_FAN_LOG+(LEVELS-1)*NODE_FAN_LOG is out of range. A write to it loads no segment, including the in-range segment that shares its low bits. A read of it returns zero with the normal read timing.
- R9: rsp_rdata is zero in every cycle where rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Segment address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W | Read data |
| seg_load | output | NSEG | Per-segment load enable |
| seg_wdata | output | DATA_W | Data for the loading segment |
| seg_rdata | input | NSEG*DATA_W | Segment contents, segment i at bits i*DATA_W upward |

## Verification
Single writes and reads go to the first segment, the last segment and the first segment of the second root half. Together with all-ones, all-zero and alternating data, these show whether the root field and the lowest field are decoded at the right bits. A write-all then read-all sweep, with data that encodes the index, separates correct decoding from any aliasing between branches at any level. Out-of-range writes use addresses whose low bits match a live segment, followed by reads of that segment. These show whether the range check happens before the tree discards the high bits. Repeated reads of one segment confirm that reads leave it untouched.

// File: rtl/dast_pkg.sv
package dast_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DESCEND = 2'd1,
        ST_ASCEND  = 2'd2
    } dast_state_e;

    // log2 of the number of nodes held at tree level k (level 0 is the root)
    function automatic int lvl_nodes_log(int k, int root_log, int node_log);
        return (k == 0) ? 0 : root_log + (k - 1) * node_log;
    endfunction

    // lowest address bit decoded by the nodes of level k
    function automatic int field_lsb(int k, int levels, int node_log);
        return (levels - 1 - k) * node_log;
    endfunction

endpackage

// File: rtl/dast_fsm.sv
module dast_fsm #(
    parameter int LEVELS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_we,
    output logic req_ready,
    output logic accept,
    output logic rsp_valid
);
    import dast_pkg::*;

    localparam int CW = $clog2(LEVELS) + 1;
    localparam logic [CW-1:0] LAST = CW'(LEVELS - 1);

    dast_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          op_we, op_we_nx;

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        op_we_nx = op_we;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin            // accept
                    state_nx = ST_DESCEND;
                    cnt_nx   = '0;
                    op_we_nx = req_we;
                end
            end
            ST_DESCEND: begin
                if (cnt == LAST) begin
                    state_nx = op_we ? ST_IDLE : ST_ASCEND;   // write_done / turn
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_ASCEND: begin
                if (cnt == LAST) begin          // respond
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            op_we <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            op_we <= op_we_nx;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        accept    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_DESCEND: ;
            ST_ASCEND:  rsp_valid = (cnt == LAST);
            default: ;
        endcase
    end

endmodule

// File: rtl/dast_down_level.sv
module dast_down_level #(
    parameter int AW      = 8,
    parameter int DW      = 64,
    parameter int PN      = 1,
    parameter int FAN_LOG = 1,
    parameter int FLSB    = 0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [PN-1:0]                        p_v,
    input  logic [PN-1:0]                        p_we,
    input  logic [PN-1:0][AW-1:0]                p_addr,
    input  logic [PN-1:0][DW-1:0]                p_wd,
    output logic [(PN<<FAN_LOG)-1:0]             c_v,
    output logic [(PN<<FAN_LOG)-1:0]             c_we,
    output logic [(PN<<FAN_LOG)-1:0][AW-1:0]     c_addr,
    output logic [(PN<<FAN_LOG)-1:0][DW-1:0]     c_wd
);
    localparam int FAN = 1 << FAN_LOG;
    localparam int CN  = PN << FAN_LOG;

    logic [CN-1:0] hit;

    // each parent node steers its request to the child named by its field
    always_comb begin
        for (int p = 0; p < PN; p++) begin
            for (int j = 0; j < FAN; j++) begin
                hit[p*FAN + j] = p_v[p] && (p_addr[p][FLSB +: FAN_LOG] == FAN_LOG'(j));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_v <= '0;
        else        c_v <= hit;
    end

    // payload registers load only on the selected branch
    always_ff @(posedge clk) begin
        for (int p = 0; p < PN; p++) begin
            for (int j = 0; j < FAN; j++) begin
                if (hit[p*FAN + j]) begin
                    c_we[p*FAN + j]   <= p_we[p];
                    c_addr[p*FAN + j] <= p_addr[p];
                    c_wd[p*FAN + j]   <= p_wd[p];
                end
            end
        end
    end

endmodule

// File: rtl/dast_up_level.sv
module dast_up_level #(
    parameter int DW      = 64,
    parameter int N       = 1,
    parameter int FAN_LOG = 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [(N<<FAN_LOG)-1:0][DW-1:0]      c_d,
    output logic [N-1:0][DW-1:0]                 n_d
);
    localparam int FAN = 1 << FAN_LOG;

    logic [N-1:0][DW-1:0] merged;

    // unselected children carry zero, so an OR merges the one live value
    always_comb begin
        for (int n = 0; n < N; n++) begin
            merged[n] = '0;
            for (int j = 0; j < FAN; j++) begin
                merged[n] = merged[n] | c_d[n*FAN + j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_d <= '0;
        else        n_d <= merged;
    end

endmodule

// File: rtl/dast_leaf_port.sv
module dast_leaf_port #(
    parameter int AW      = 8,
    parameter int DW      = 64,
    parameter int N       = 32,
    parameter int FAN_LOG = 2
) (
    input  logic [N-1:0]                         l_v,
    input  logic [N-1:0]                         l_we,
    input  logic [N-1:0][AW-1:0]                 l_addr,
    input  logic [N-1:0][DW-1:0]                 l_wd,
    input  logic [(N<<FAN_LOG)*DW-1:0]           seg_rdata,
    output logic [(N<<FAN_LOG)-1:0]              seg_load,
    output logic [DW-1:0]                        seg_wdata,
    output logic [(N<<FAN_LOG)-1:0][DW-1:0]      rd_data
);
    localparam int FAN = 1 << FAN_LOG;

    wire unused_addr = ^l_addr;

    always_comb begin
        seg_wdata = '0;
        for (int n = 0; n < N; n++) begin
            if (l_v[n] && l_we[n]) seg_wdata = seg_wdata | l_wd[n];
            for (int j = 0; j < FAN; j++) begin
                automatic logic hit = l_v[n] && (l_addr[n][FAN_LOG-1:0] == FAN_LOG'(j));
                seg_load[n*FAN + j] = hit && l_we[n];
                rd_data[n*FAN + j]  = (hit && !l_we[n]) ? seg_rdata[(n*FAN + j)*DW +: DW] : '0;
            end
        end
    end

endmodule

// File: rtl/dast_tree.sv
module dast_tree #(
    parameter int DATA_W       = 64,
    parameter int LEVELS       = 4,
    parameter int ROOT_FAN_LOG = 1,
    parameter int NODE_FAN_LOG = 2,
    parameter int ADDR_W       = 8,
    localparam int USED_W      = ROOT_FAN_LOG + (LEVELS - 1) * NODE_FAN_LOG,
    localparam int NSEG        = 1 << USED_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [NSEG-1:0]          seg_load,
    output logic [DATA_W-1:0]        seg_wdata,
    input  logic [NSEG*DATA_W-1:0]   seg_rdata
);
    import dast_pkg::*;

    localparam int MAXN = NSEG >> NODE_FAN_LOG;   // nodes in the deepest level

    logic accept;

    dast_fsm #(.LEVELS(LEVELS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid)
    );

    // root node registers
    logic              rt_v, rt_we;
    logic [ADDR_W-1:0] rt_addr;
    logic [DATA_W-1:0] rt_wd;
    logic              in_range;

    assign in_range = ((req_addr >> USED_W) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_v <= 1'b0;
        else        rt_v <= accept && in_range;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            rt_we   <= req_we;
            rt_addr <= req_addr;
            rt_wd   <= req_wdata;
        end
    end

    wire [LEVELS-1:0][MAXN-1:0]              dn_v;
    wire [LEVELS-1:0][MAXN-1:0]              dn_we;
    wire [LEVELS-1:0][MAXN-1:0][ADDR_W-1:0]  dn_addr;
    wire [LEVELS-1:0][MAXN-1:0][DATA_W-1:0]  dn_wd;
    wire [LEVELS-1:0][MAXN-1:0][DATA_W-1:0]  up_d;
    wire [NSEG-1:0][DATA_W-1:0]              leaf_rd;

    assign dn_v[0][0]    = rt_v;
    assign dn_we[0][0]   = rt_we;
    assign dn_addr[0][0] = rt_addr;
    assign dn_wd[0][0]   = rt_wd;

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int NK   = 1 << lvl_nodes_log(k, ROOT_FAN_LOG, NODE_FAN_LOG);
        localparam int FLOG = (k == 0) ? ROOT_FAN_LOG : NODE_FAN_LOG;

        if (k > 0) begin : g_dn
            localparam int PN   = 1 << lvl_nodes_log(k - 1, ROOT_FAN_LOG, NODE_FAN_LOG);
            localparam int PLOG = (k == 1) ? ROOT_FAN_LOG : NODE_FAN_LOG;
            dast_down_level #(
                .AW      (ADDR_W),
                .DW      (DATA_W),
                .PN      (PN),
                .FAN_LOG (PLOG),
                .FLSB    (field_lsb(k - 1, LEVELS, NODE_FAN_LOG))
            ) u_dn (
                .clk    (clk),
                .rst_n  (rst_n),
                .p_v    (dn_v[k-1][PN-1:0]),
                .p_we   (dn_we[k-1][PN-1:0]),
                .p_addr (dn_addr[k-1][PN-1:0]),
                .p_wd   (dn_wd[k-1][PN-1:0]),
                .c_v    (dn_v[k][NK-1:0]),
                .c_we   (dn_we[k][NK-1:0]),
                .c_addr (dn_addr[k][NK-1:0]),
                .c_wd   (dn_wd[k][NK-1:0])
            );
        end

        if (NK < MAXN) begin : g_pad
            assign dn_v[k][MAXN-1:NK]    = '0;
            assign dn_we[k][MAXN-1:NK]   = '0;
            assign dn_addr[k][MAXN-1:NK] = '0;
            assign dn_wd[k][MAXN-1:NK]   = '0;
            assign up_d[k][MAXN-1:NK]    = '0;
        end

        if (k < LEVELS - 1) begin : g_up
            dast_up_level #(.DW(DATA_W), .N(NK), .FAN_LOG(FLOG)) u_up (
                .clk   (clk),
                .rst_n (rst_n),
                .c_d   (up_d[k+1][(NK<<FLOG)-1:0]),
                .n_d   (up_d[k][NK-1:0])
            );
        end else begin : g_leaf
            dast_leaf_port #(.AW(ADDR_W), .DW(DATA_W), .N(NK), .FAN_LOG(FLOG)) u_leaf (
                .l_v       (dn_v[k][NK-1:0]),
                .l_we      (dn_we[k][NK-1:0]),
                .l_addr    (dn_addr[k][NK-1:0]),
                .l_wd      (dn_wd[k][NK-1:0]),
                .seg_rdata (seg_rdata),
                .seg_load  (seg_load),
                .seg_wdata (seg_wdata),
                .rd_data   (leaf_rd)
            );
            dast_up_level #(.DW(DATA_W), .N(NK), .FAN_LOG(FLOG)) u_up (
                .clk   (clk),
                .rst_n (rst_n),
                .c_d   (leaf_rd),
                .n_d   (up_d[k][NK-1:0])
            );
        end
    end

    wire unused_pad = ^{dn_v, dn_we, dn_addr, dn_wd, up_d};

    assign rsp_rdata = rsp_valid ? up_d[0][0] : '0;

endmodule

// File: rtl/dast_checker.sv
module dast_checker #(
    parameter int LEVELS = 4,
    parameter int ADDR_W = 8,
    parameter int USED_W = 7,
    parameter int NSEG   = 128,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [NSEG-1:0]   seg_load
);
    logic [15:0] since;     // cycles since the last accepted request
    logic        lat_we;
    logic        lat_oor;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since   <= '0;
            lat_we  <= 1'b0;
            lat_oor <= 1'b0;
        end else if (req_valid && req_ready) begin
            since   <= 16'd1;
            lat_we  <= req_we;
            lat_oor <= ((req_addr >> USED_W) != '0);
        end else if (since != '0 && since < 16'(2 * LEVELS + 1)) begin
            since <= since + 16'd1;
        end
    end

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_after_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    p_load_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|seg_load) |-> (since == 16'(LEVELS) && lat_we && !lat_oor));

    p_load_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_load));

    p_resp_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (since == 16'(2 * LEVELS) && !lat_we));

    p_read_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since != '0 && !lat_we) |-> (seg_load == '0));

    p_oor_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lat_oor) |-> (rsp_rdata == '0));

    p_quiet_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0));

endmodule

bind dast_tree dast_checker #(
    .LEVELS (LEVELS),
    .ADDR_W (ADDR_W),
    .USED_W (USED_W),
    .NSEG   (NSEG),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .seg_load  (seg_load)
);

// File: tb/tb_dast_tree.sv
`timescale 1ns/1ps
module tb_dast_tree;
    localparam int LV = 4;
    localparam int AW = 8;
    localparam int DW = 64;
    localparam int NS = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic [NS-1:0]     seg_load;
    logic [DW-1:0]     seg_wdata;
    logic [NS*DW-1:0]  seg_rdata;

    always #2 clk = ~clk;   // 250 MHz

    dast_tree #(.DATA_W(DW), .LEVELS(LV), .ROOT_FAN_LOG(1), .NODE_FAN_LOG(2), .ADDR_W(AW)) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_we (req_we), .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .seg_load (seg_load),
        .seg_wdata (seg_wdata), .seg_rdata (seg_rdata)
    );

    // segment storage outside the block
    logic [DW-1:0] seg_mem [NS];
    logic [DW-1:0] ref_mem [NS];

    always_comb begin
        for (int i = 0; i < NS; i++) seg_rdata[i*DW +: DW] = seg_mem[i];
    end

    always @(posedge clk) begin
        for (int i = 0; i < NS; i++) if (seg_load[i]) seg_mem[i] <= seg_wdata;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        int            due;
        bit            is_rd;
        int            idx;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [DW-1:0] pat(int i);
        return {8'hA5, 24'(i), 32'(i * 7919 + 3)};
    endfunction

    // monitor: pops expected events as the block produces them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!rsp_valid) chk(rsp_rdata == '0, "R9", "idle rdata", rsp_rdata, '0);
            if ((|seg_load) || rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, (|seg_load) ? "R5" : "R6", "unexpected event", DW'(cyc), '0);
                end else begin
                    automatic exp_t e = sb.pop_front();
                    chk(e.due == cyc, e.tag, "event cycle", DW'(cyc), DW'(e.due));
                    if (e.is_rd) begin
                        chk(rsp_valid && seg_load == '0, "R7", "read kind", DW'(seg_load), '0);
                        chk(rsp_rdata == e.data, e.tag, "read data", rsp_rdata, e.data);
                    end else begin
                        automatic logic [NS-1:0] oh = '0;
                        oh[e.idx] = 1'b1;
                        chk(!rsp_valid && seg_load == oh, "R5", "load vector",
                            DW'($clog2(seg_load)), DW'(e.idx));
                        chk(seg_wdata == e.data, e.tag, "write data", seg_wdata, e.data);
                    end
                end
            end else if (sb.size() > 0 && sb[0].due < cyc) begin
                chk(1'b0, sb[0].tag, "missing event", DW'(cyc), DW'(sb[0].due));
                void'(sb.pop_front());
            end
        end
    end

    // driver: issues one access and queues what it must produce
    task automatic access(bit we, int addr, logic [DW-1:0] d, string tag);
        int c0;
        bit inr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = AW'(addr);
        req_wdata = d;
        c0  = cyc;
        inr = (addr < NS);
        if (we && inr) begin
            sb.push_back('{c0 + LV, 1'b0, addr, d, tag});
            ref_mem[addr] = d;
        end
        if (!we) sb.push_back('{c0 + 2*LV, 1'b1, addr, inr ? ref_mem[addr] : '0, tag});
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", DW'(req_ready), '0);
        while (!req_ready) @(negedge clk);
        chk(cyc == c0 + (we ? LV : 2*LV) + 1, "R2", "ready return cycle",
            DW'(cyc), DW'(c0 + (we ? LV : 2*LV) + 1));
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            seg_mem[i] = pat(i) ^ 64'h0F0F;
            ref_mem[i] = pat(i) ^ 64'h0F0F;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", DW'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", DW'(rsp_valid), '0);
        chk(seg_load == '0, "R1", "reset seg_load", DW'(|seg_load), '0);
        chk(rsp_rdata == '0, "R1", "reset rdata", rsp_rdata, '0);
        rst_n = 1'b1;

        // R4, R6: corner segments and distinct data patterns
        access(1'b1, 0,      '1,                     "R4");
        access(1'b1, NS - 1, 64'h0123_4567_89AB_CDEF, "R4");
        access(1'b1, NS / 2, 64'hAAAA_5555_AAAA_5555, "R4");
        access(1'b1, 1,      '0,                     "R4");
        access(1'b0, 0,      '0, "R6");
        access(1'b0, NS - 1, '0, "R6");
        access(1'b0, NS / 2, '0, "R6");
        access(1'b0, 1,      '0, "R6");

        // R3: sweep every segment with index-coded data, then read all back
        for (int i = 0; i < NS; i++) access(1'b1, i, pat(i), "R3");
        for (int i = 0; i < NS; i++) access(1'b0, i, '0, "R3");

        // R7: repeated reads leave the segment untouched
        access(1'b0, 10, '0, "R7");
        access(1'b0, 10, '0, "R7");
        access(1'b0, 11, '0, "R7");

        // R8: out-of-range writes must not alias onto live segments
        access(1'b1, NS + 5,  64'hDEAD_BEEF_DEAD_BEEF, "R8");
        access(1'b1, 2*NS - 1, 64'hFFFF_0000_FFFF_0000, "R8");
        access(1'b0, 5,      '0, "R8");
        access(1'b0, NS - 1, '0, "R8");
        access(1'b0, NS + 5, '0, "R8");
        access(1'b0, 200,    '0, "R8");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R6", "pending events", DW'(sb.size()), '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule